// File: doc/BRIEF.md
# Instrument Status Byte and Service Request

This block builds the 8-bit status byte of an instrument's remote-control port and produces the service request that goes with it. Three summary bits are formed from plain inputs: a message-available flag from the output queue, the standard event register under its enable mask, and the operation register under its enable mask. A service-request enable register, written through a simple write strobe, selects which status bits feed the master summary.

Bit 6 is shared by two read paths. A serial poll returns the latched request-service flag in bit 6 and clears that flag as part of the poll. A status query returns the live master summary in bit 6 and leaves all state untouched. The request-service flag is set when the master summary rises. While the flag is set, an active-low service-request line is driven low.

Top module: `status_byte_unit`

## Requirements
- R1: Bits 0 to 3 of every byte returned by a serial poll or a status query are 0.
- R2: Bit 4 (weight 16) equals the message-available input. A serial poll does not change it.
- R3: Bit 5 (weight 32) is 1 exactly when some bit of the standard event register and the same bit of its enable mask are both 1.
- R4: Bit 7 (weight 128) is 1 exactly when some bit of the operation register and the same bit of its enable mask are both 1.
- R5: A serial poll returns bit 6 equal to the request-service flag before the poll and clears that flag. Bits 0 to 5 and 7 of the returned byte are the same as a query would give.
- R6: A status query returns bit 6 equal to the master summary. It changes neither the master summary nor the request-service flag.
- R7: The master summary is the OR over status bits 0 to 5 and 7, each ANDed with the same bit of the service-request enable register. Enable bit 6 has no effect.
- R8: The request-service flag is set on the clock edge at which the master summary is first seen high after being low. It stays set until a serial poll. `srq_n` is 0 exactly while the flag is set.
- R9: When a serial poll and a rising master summary fall in the same cycle, the poll returns bit 6 as 0 if the flag was clear before the poll. The flag is set one cycle later, so `srq_n` goes low two clock edges after the request.
- R10: Reset clears the request-service flag (`srq_n` = 1), the enable register (`sre_val` = 0) and both valid outputs.
- R11: A poll or query request held for one cycle produces its byte, together with a one-cycle valid pulse, on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| msg_avail | input | 1 | Output queue holds unread data |
| evt_reg | input | EVT_W | Standard event register contents |
| evt_en | input | EVT_W | Standard event enable mask |
| oper_reg | input | OPR_W | Operation status register contents |
| oper_en | input | OPR_W | Operation status enable mask |
| sre_wr | input | 1 | Write strobe for the service-request enable register |
| sre_din | input | 8 | Write data for the service-request enable register |
| poll_req | input | 1 | Serial-poll read request |
| query_req | input | 1 | Status-query read request |
| sre_val | output | 8 | Current service-request enable register |
| poll_byte | output | 8 | Byte returned by the last serial poll |
| poll_valid | output | 1 | One-cycle pulse when poll_byte is new |
| query_byte | output | 8 | Byte returned by the last status query |
| query_valid | output | 1 | One-cycle pulse when query_byte is new |
| srq_n | output | 1 | Active-low service-request line |

## Verification
The assertions take it for granted that every request input is synchronous to `clk` and that each `poll_req` or `query_req` is an isolated one-cycle pulse. They also rely on the summary inputs being stable across the cycle in which a request is sampled, because the returned byte is compared with the inputs one cycle earlier. The bench drives all inputs on the falling edge and raises each request for exactly one cycle. It changes register and mask inputs only between reads, except in the collision scenario. There the message flag and the poll request are raised on the same edge on purpose.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int STB_W   = 8;
  localparam int MAV_POS = 4;
  localparam int ESB_POS = 5;
  localparam int RQS_POS = 6;
  localparam int OSB_POS = 7;
  // bits allowed to feed the master summary (bit 6 excluded)
  localparam logic [STB_W-1:0] SUM_MASK = ~(8'h01 << RQS_POS);
  typedef logic [STB_W-1:0] stb_t;
endpackage

// File: rtl/stb_summary.sv
module stb_summary
  import stb_pkg::*;
#(
  parameter int EVT_W = 8,
  parameter int OPR_W = 16
) (
  input  logic             msg_avail,
  input  logic [EVT_W-1:0] evt_reg,
  input  logic [EVT_W-1:0] evt_en,
  input  logic [OPR_W-1:0] oper_reg,
  input  logic [OPR_W-1:0] oper_en,
  input  stb_t             sre,
  output stb_t             stb_base,
  output logic             mss
);
  logic evt_sum;
  logic opr_sum;

  assign evt_sum = |(evt_reg & evt_en);
  assign opr_sum = |(oper_reg & oper_en);

  always_comb begin
    stb_base          = '0;
    stb_base[MAV_POS] = msg_avail;
    stb_base[ESB_POS] = evt_sum;
    stb_base[OSB_POS] = opr_sum;
  end

  assign mss = |(stb_base & sre & SUM_MASK);
endmodule

// File: rtl/srq_engine.sv
module srq_engine (
  input  logic clk,
  input  logic rst_n,
  input  logic mss,
  input  logic poll_req,
  output logic rqs,
  output logic srq_n
);
  logic mss_q, mss_d;
  logic rqs_q, rqs_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = mss & ~mss_q;

  always_comb begin
    mss_d = mss;
    if (poll_req) begin
      rqs_d  = 1'b0;
      pend_d = rise;
    end else begin
      rqs_d  = rqs_q | rise | pend_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mss_q  <= 1'b0;
      rqs_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mss_q  <= mss_d;
      rqs_q  <= rqs_d;
      pend_q <= pend_d;
    end
  end

  assign rqs   = rqs_q;
  assign srq_n = ~rqs_q;
endmodule

// File: rtl/stb_readout.sv
module stb_readout
  import stb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic poll_req,
  input  logic query_req,
  input  stb_t stb_base,
  input  logic rqs,
  input  logic mss,
  output stb_t poll_byte,
  output logic poll_valid,
  output stb_t query_byte,
  output logic query_valid
);
  stb_t poll_d, query_d;
  stb_t poll_q, query_q;
  logic pv_q, qv_q;

  always_comb begin
    poll_d           = stb_base;
    poll_d[RQS_POS]  = rqs;
    query_d          = stb_base;
    query_d[RQS_POS] = mss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q  <= '0;
      query_q <= '0;
      pv_q    <= 1'b0;
      qv_q    <= 1'b0;
    end else begin
      pv_q <= poll_req;
      qv_q <= query_req;
      if (poll_req)  poll_q  <= poll_d;
      if (query_req) query_q <= query_d;
    end
  end

  assign poll_byte   = poll_q;
  assign poll_valid  = pv_q;
  assign query_byte  = query_q;
  assign query_valid = qv_q;
endmodule

// File: rtl/status_byte_unit.sv
module status_byte_unit
  import stb_pkg::*;
#(
  parameter int EVT_W = 8,
  parameter int OPR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_avail,
  input  logic [EVT_W-1:0] evt_reg,
  input  logic [EVT_W-1:0] evt_en,
  input  logic [OPR_W-1:0] oper_reg,
  input  logic [OPR_W-1:0] oper_en,
  input  logic             sre_wr,
  input  logic [7:0]       sre_din,
  input  logic             poll_req,
  input  logic             query_req,
  output logic [7:0]       sre_val,
  output logic [7:0]       poll_byte,
  output logic             poll_valid,
  output logic [7:0]       query_byte,
  output logic             query_valid,
  output logic             srq_n
);
  stb_t sre_q, sre_d;
  stb_t stb_base;
  logic mss_w;
  logic rqs_w;

  always_comb begin
    sre_d = sre_q;
    if (sre_wr) sre_d = sre_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sre_q <= '0;
    else        sre_q <= sre_d;
  end

  stb_summary #(.EVT_W(EVT_W), .OPR_W(OPR_W)) u_sum (
    .msg_avail (msg_avail),
    .evt_reg   (evt_reg),
    .evt_en    (evt_en),
    .oper_reg  (oper_reg),
    .oper_en   (oper_en),
    .sre       (sre_q),
    .stb_base  (stb_base),
    .mss       (mss_w)
  );

  srq_engine u_srq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mss      (mss_w),
    .poll_req (poll_req),
    .rqs      (rqs_w),
    .srq_n    (srq_n)
  );

  stb_readout u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_req    (poll_req),
    .query_req   (query_req),
    .stb_base    (stb_base),
    .rqs         (rqs_w),
    .mss         (mss_w),
    .poll_byte   (poll_byte),
    .poll_valid  (poll_valid),
    .query_byte  (query_byte),
    .query_valid (query_valid)
  );

  assign sre_val = sre_q;
endmodule

// File: rtl/status_byte_unit_chk.sv
module status_byte_unit_chk #(
  parameter int EVT_W = 8,
  parameter int OPR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_avail,
  input logic [EVT_W-1:0] evt_reg,
  input logic [EVT_W-1:0] evt_en,
  input logic [OPR_W-1:0] oper_reg,
  input logic [OPR_W-1:0] oper_en,
  input logic             poll_req,
  input logic             query_req,
  input logic [7:0]       poll_byte,
  input logic             poll_valid,
  input logic [7:0]       query_byte,
  input logic             query_valid,
  input logic             srq_n,
  input logic             mss
);
  // R1
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_valid || query_valid) |-> (poll_byte[3:0] == 4'h0 && query_byte[3:0] == 4'h0));

  // R2
  mav_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> poll_byte[4] == $past(msg_avail));

  // R4
  oper_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    query_req |=> query_byte[7] == $past(|(oper_reg & oper_en)));

  // R3
  evt_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    query_req |=> query_byte[5] == $past(|(evt_reg & evt_en)));

  // R5
  poll_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> srq_n);

  // R5
  poll_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> poll_byte[6] == !$past(srq_n));

  // R6
  query_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    query_req |=> query_byte[6] == $past(mss));

  // R8
  srq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srq_n && !poll_req) |=> !srq_n);

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !query_req) |=> (poll_valid && !query_valid));
endmodule

bind status_byte_unit status_byte_unit_chk #(.EVT_W(EVT_W), .OPR_W(OPR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_avail   (msg_avail),
  .evt_reg     (evt_reg),
  .evt_en      (evt_en),
  .oper_reg    (oper_reg),
  .oper_en     (oper_en),
  .poll_req    (poll_req),
  .query_req   (query_req),
  .poll_byte   (poll_byte),
  .poll_valid  (poll_valid),
  .query_byte  (query_byte),
  .query_valid (query_valid),
  .srq_n       (srq_n),
  .mss         (mss_w)
);

// File: tb/sim_status_byte_unit.sv
`timescale 1ns/1ps
module sim_status_byte_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_avail;
  logic [7:0]  evt_reg, evt_en;
  logic [15:0] oper_reg, oper_en;
  logic        sre_wr;
  logic [7:0]  sre_din;
  logic        poll_req, query_req;
  logic [7:0]  sre_val, poll_byte, query_byte;
  logic        poll_valid, query_valid, srq_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  status_byte_unit u0 (
    .clk(clk), .rst_n(rst_n), .msg_avail(msg_avail),
    .evt_reg(evt_reg), .evt_en(evt_en), .oper_reg(oper_reg), .oper_en(oper_en),
    .sre_wr(sre_wr), .sre_din(sre_din), .poll_req(poll_req), .query_req(query_req),
    .sre_val(sre_val), .poll_byte(poll_byte), .poll_valid(poll_valid),
    .query_byte(query_byte), .query_valid(query_valid), .srq_n(srq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_poll(output logic [7:0] b, output logic v);
    @(negedge clk) poll_req = 1'b1;
    @(negedge clk) poll_req = 1'b0;
    b = poll_byte; v = poll_valid;
  endtask

  task automatic do_query(output logic [7:0] b, output logic v);
    @(negedge clk) query_req = 1'b1;
    @(negedge clk) query_req = 1'b0;
    b = query_byte; v = query_valid;
  endtask

  task automatic write_sre(input logic [7:0] d);
    @(negedge clk) begin sre_wr = 1'b1; sre_din = d; end
    @(negedge clk) sre_wr = 1'b0;
  endtask

  task automatic clear_inputs();
    @(negedge clk);
    msg_avail = 1'b0; evt_reg = '0; evt_en = '0; oper_reg = '0; oper_en = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; msg_avail = 0; evt_reg = 0; evt_en = 0; oper_reg = 0; oper_en = 0;
    sre_wr = 0; sre_din = 0; poll_req = 0; query_req = 0;
    tick(3);
    check("R10 srq_n", {7'b0, srq_n}, 8'h01);
    check("R10 sre_val", sre_val, 8'h00);
    check("R10 valids", {6'b0, poll_valid, query_valid}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_mav();
    logic [7:0] b; logic v;
    @(negedge clk) msg_avail = 1'b1;
    do_query(b, v);
    check("R2 query mav", b, 8'h10);
    check("R11 query valid", {7'b0, v}, 8'h01);
    do_poll(b, v);
    check("R2 poll mav", b, 8'h10);
    check("R11 poll valid", {7'b0, v}, 8'h01);
    tick(1);
    check("R11 valid one cycle", {7'b0, poll_valid}, 8'h00);
    do_poll(b, v);
    check("R2 mav kept after poll", b, 8'h10);
    @(negedge clk) msg_avail = 1'b0;
    do_query(b, v);
    check("R1 R2 empty byte", b, 8'h00);
  endtask

  task automatic t_summaries();
    logic [7:0] b; logic v;
    @(negedge clk) begin evt_reg = 8'h04; evt_en = 8'h00; end
    do_query(b, v);
    check("R3 masked event", b, 8'h00);
    @(negedge clk) evt_en = 8'h04;
    do_query(b, v);
    check("R3 enabled event", b, 8'h20);
    @(negedge clk) begin oper_reg = 16'h0100; oper_en = 16'h0100; end
    do_query(b, v);
    check("R4 enabled oper", b, 8'hA0);
    @(negedge clk) oper_en = 16'h0001;
    do_query(b, v);
    check("R4 masked oper", b, 8'h20);
    check("R7 no enable no srq", {7'b0, srq_n}, 8'h01);
    clear_inputs();
  endtask

  task automatic t_service();
    logic [7:0] b; logic v;
    @(negedge clk) msg_avail = 1'b1;
    write_sre(8'h40);
    tick(2);
    check("R7 bit6 enable ignored", {7'b0, srq_n}, 8'h01);
    do_query(b, v);
    check("R7 mss off", b, 8'h10);
    write_sre(8'h10);
    check("R10 sre readback", sre_val, 8'h10);
    tick(1);
    check("R8 srq asserted", {7'b0, srq_n}, 8'h00);
    tick(5);
    check("R8 srq held", {7'b0, srq_n}, 8'h00);
    do_query(b, v);
    check("R6 query shows mss", b, 8'h50);
    check("R6 query keeps rqs", {7'b0, srq_n}, 8'h00);
    do_poll(b, v);
    check("R5 poll shows rqs", b, 8'h50);
    check("R5 poll clears rqs", {7'b0, srq_n}, 8'h01);
    do_poll(b, v);
    check("R5 second poll", b, 8'h10);
    do_query(b, v);
    check("R6 mss unchanged by poll", b, 8'h50);
  endtask

  task automatic t_collision();
    logic [7:0] b;
    @(negedge clk) msg_avail = 1'b0;
    tick(3);
    @(negedge clk) begin msg_avail = 1'b1; poll_req = 1'b1; end
    @(negedge clk) poll_req = 1'b0;
    b = poll_byte;
    check("R9 poll sees pre-edge value", b, 8'h10);
    check("R9 rqs not yet set", {7'b0, srq_n}, 8'h01);
    tick(1);
    check("R9 rqs set next cycle", {7'b0, srq_n}, 8'h00);
  endtask

  task automatic t_reset_mid();
    @(negedge clk) rst_n = 1'b0;
    tick(1);
    check("R10 mid reset srq", {7'b0, srq_n}, 8'h01);
    check("R10 mid reset sre", sre_val, 8'h00);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_mav();
    t_summaries();
    t_service();
    t_collision();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule